// File: doc/BRIEF.md
# Raster Video Format Sequencer

The sequencer paces the readout of a 312-pixel by 287-line photodiode array clocked at 6 MHz. Two cascaded position counters walk the raster one pixel clock at a time. From the current position the block decides, on every clock, whether the analog output multiplexer should emit the sync level, the blanking level or picture data. It drives that choice as a 2-bit code: 00 means blank, 01 means sync and 10 means image. Code 11 is reserved, and a receiver treats it as blank.

Alongside the level code the block issues the readout strobes:
- a row-advance pulse for the vertical scan register at the head of each active line;
- a column-advance pulse for the horizontal scan register on every active pixel;
- a calibration window, placed just after each line's sync pulse, in which the column amplifiers may null their offsets;
- a field-start pulse for downstream blocks such as exposure control.

When the test input is high, the sensor samples are replaced by a self-generated checkerboard. Its square edge is 2^SQ_LOG2 pixels, so the picture can be shown on a monitor or captured by a frame grabber.

All outputs are registered and describe the raster position the counters hold after each clock edge. Line length, field length, sync width, back porch, active size, calibration length and square size are parameters.

Top module: `raster_fmt_seq`

## Requirements
- R1: While reset is held, lvl_sel is 00 (blank), data_out is 0, and row_adv, col_adv, cal_win and field_start are all 0. The first clock after reset is released lands on pixel 0 of line 0.
- R2: A line lasts H_TOTAL clocks. On lines that are not vertical-sync lines, pixels 0 to H_SYNC_W-1 emit lvl_sel = 01 (sync).
- R3: Lines 0 to V_SYNC_L-1 are vertical-sync lines. On these lines, pixels 0 to H_TOTAL-H_SYNC_W-1 emit 01 (a broad pulse) and the remaining pixels emit 00.
- R4: Active lines are V_SYNC_L+V_BP_L up to V_ACTIVE lines later. Active pixels are H_SYNC_W+H_BP up to H_ACTIVE pixels later. On every active pixel of an active line, lvl_sel is 10 and col_adv is 1. Everywhere outside sync and active pixels, lvl_sel is 00 and col_adv is 0. Code 11 never appears.
- R5: With test_en low, data_out on an active pixel equals the pix_in value sampled on the edge that entered that pixel. On every other pixel data_out is 0.
- R6: With test_en high, data_out on an active pixel is all ones when bit SQ_LOG2 of the pixel index XOR bit SQ_LOG2 of the line index is 1, and 0 otherwise. Both indices count from 0 at the first active pixel and the first active line.
- R7: On every line that is not a vertical-sync line, cal_win is 1 for pixels H_SYNC_W to H_SYNC_W+CAL_W-1 and 0 elsewhere. cal_win is never 1 together with col_adv.
- R8: row_adv is a one-clock pulse at pixel 0 of each active line and is 0 on all other clocks.
- R9: field_start is a one-clock pulse at pixel 0 of line 0. Consecutive pulses are exactly H_TOTAL*V_TOTAL clocks apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| test_en | input | 1 | Selects the checkerboard in place of sensor data |
| pix_in | input | PIX_W | Digitized sensor sample for the current pixel |
| lvl_sel | output | 2 | Output level code: 00 blank, 01 sync, 10 image |
| data_out | output | PIX_W | Picture data for the image level, zero otherwise |
| row_adv | output | 1 | Row-select strobe for the vertical scan |
| col_adv | output | 1 | Column-advance strobe for the horizontal scan |
| cal_win | output | 1 | Column amplifier offset-compensation window |
| field_start | output | 1 | One-clock pulse at the start of each field |

## Verification
The properties assume that the parameters are consistent: CAL_W does not exceed H_BP, each porch-plus-active sum fits within its total, and SQ_LOG2 is smaller than both counter widths. They also assume that test_en and pix_in are synchronous to clk, although any value is allowed on any cycle. The stimulus uses a reduced raster so that several fields finish quickly. It changes test_en and pix_in only away from the rising edge, covering whole fields in each mode, fields with test_en flipping at random per pixel, and a reset applied in the middle of a field. A behavioural position model in the bench predicts every output on every clock.

// File: rtl/raster_fmt_pkg.sv
package raster_fmt_pkg;

    typedef enum logic [1:0] {
        LVL_BLANK = 2'b00,
        LVL_SYNC  = 2'b01,
        LVL_IMAGE = 2'b10,
        LVL_RSVD  = 2'b11
    } lvl_e;

    // Region flags for one raster position
    typedef struct packed {
        logic vsync_line;
        logic hsync;
        logic broad;
        logic act_h;
        logic act_v;
        logic cal;
        logic line_head;
        logic field_head;
    } region_t;

endpackage

// File: rtl/raster_scan_counter.sv
module raster_scan_counter #(
    parameter int TOTAL = 384,
    localparam int W = $clog2(TOTAL)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    output logic [W-1:0] cnt_q,
    output logic [W-1:0] cnt_d,
    output logic         wrap
);
    localparam logic [W-1:0] LAST = W'(TOTAL - 1);

    // Wraps to zero after LAST; resets to LAST so that the first step enters 0
    always_comb begin
        wrap  = step && (cnt_q == LAST);
        cnt_d = cnt_q;
        if (step) begin
            cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= LAST;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/raster_region_decode.sv
module raster_region_decode
    import raster_fmt_pkg::*;
#(
    parameter int H_TOTAL  = 384,
    parameter int H_SYNC_W = 28,
    parameter int H_BP     = 32,
    parameter int H_ACTIVE = 312,
    parameter int CAL_W    = 16,
    parameter int V_TOTAL  = 312,
    parameter int V_SYNC_L = 3,
    parameter int V_BP_L   = 14,
    parameter int V_ACTIVE = 287,
    localparam int HW = $clog2(H_TOTAL),
    localparam int VW = $clog2(V_TOTAL)
) (
    input  logic [HW-1:0] h,
    input  logic [VW-1:0] v,
    output region_t       rgn,
    output logic [HW-1:0] hoff,
    output logic [VW-1:0] voff
);
    localparam logic [HW-1:0] H_SYNC_END  = HW'(H_SYNC_W);
    localparam logic [HW-1:0] H_BROAD_END = HW'(H_TOTAL - H_SYNC_W);
    localparam logic [HW-1:0] H_ACT_BEG   = HW'(H_SYNC_W + H_BP);
    localparam logic [HW-1:0] H_ACT_END   = HW'(H_SYNC_W + H_BP + H_ACTIVE);
    localparam logic [HW-1:0] H_CAL_END   = HW'(H_SYNC_W + CAL_W);
    localparam logic [VW-1:0] V_SYNC_END  = VW'(V_SYNC_L);
    localparam logic [VW-1:0] V_ACT_BEG   = VW'(V_SYNC_L + V_BP_L);
    localparam logic [VW-1:0] V_ACT_END   = VW'(V_SYNC_L + V_BP_L + V_ACTIVE);

    always_comb begin
        rgn.vsync_line = (v < V_SYNC_END);
        rgn.hsync      = (h < H_SYNC_END);
        rgn.broad      = (h < H_BROAD_END);
        rgn.act_h      = (h >= H_ACT_BEG) && (h < H_ACT_END);
        rgn.act_v      = (v >= V_ACT_BEG) && (v < V_ACT_END);
        rgn.cal        = !rgn.vsync_line && (h >= H_SYNC_END) && (h < H_CAL_END);
        rgn.line_head  = (h == '0);
        rgn.field_head = (h == '0) && (v == '0);
        hoff           = h - H_ACT_BEG;
        voff           = v - V_ACT_BEG;
    end
endmodule

// File: rtl/raster_level_mux.sv
module raster_level_mux
    import raster_fmt_pkg::*;
#(
    parameter int PIX_W   = 8,
    parameter int SQ_LOG2 = 4,
    parameter int HW      = 9,
    parameter int VW      = 9
) (
    input  region_t          rgn,
    input  logic             test_en,
    input  logic [PIX_W-1:0] pix_in,
    input  logic [HW-1:0]    hoff,
    input  logic [VW-1:0]    voff,
    output lvl_e             lvl,
    output logic [PIX_W-1:0] data
);
    logic tile;

    assign tile = hoff[SQ_LOG2] ^ voff[SQ_LOG2];

    always_comb begin
        lvl  = LVL_BLANK;
        data = '0;
        if (rgn.vsync_line) begin
            lvl = rgn.broad ? LVL_SYNC : LVL_BLANK;
        end else if (rgn.hsync) begin
            lvl = LVL_SYNC;
        end else if (rgn.act_h && rgn.act_v) begin
            lvl  = LVL_IMAGE;
            data = test_en ? {PIX_W{tile}} : pix_in;
        end
    end
endmodule

// File: rtl/raster_fmt_seq.sv
module raster_fmt_seq
    import raster_fmt_pkg::*;
#(
    parameter int PIX_W    = 8,
    parameter int H_TOTAL  = 384,
    parameter int H_SYNC_W = 28,
    parameter int H_BP     = 32,
    parameter int H_ACTIVE = 312,
    parameter int CAL_W    = 16,
    parameter int V_TOTAL  = 312,
    parameter int V_SYNC_L = 3,
    parameter int V_BP_L   = 14,
    parameter int V_ACTIVE = 287,
    parameter int SQ_LOG2  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             test_en,
    input  logic [PIX_W-1:0] pix_in,
    output logic [1:0]       lvl_sel,
    output logic [PIX_W-1:0] data_out,
    output logic             row_adv,
    output logic             col_adv,
    output logic             cal_win,
    output logic             field_start
);
    localparam int HW = $clog2(H_TOTAL);
    localparam int VW = $clog2(V_TOTAL);

    typedef struct packed {
        lvl_e             lvl;
        logic [PIX_W-1:0] data;
        logic             row;
        logic             col;
        logic             cal;
        logic             fs;
    } seq_t;

    logic [HW-1:0] h_q, h_d;
    logic [VW-1:0] v_q, v_d;
    logic          h_wrap, v_wrap;
    region_t       rgn;
    logic [HW-1:0] hoff;
    logic [VW-1:0] voff;
    lvl_e          lvl_n;
    logic [PIX_W-1:0] data_n;
    seq_t          seq_d, seq_q;

    raster_scan_counter #(.TOTAL(H_TOTAL)) i_hcnt (
        .clk(clk), .rst_n(rst_n), .step(1'b1),
        .cnt_q(h_q), .cnt_d(h_d), .wrap(h_wrap)
    );

    raster_scan_counter #(.TOTAL(V_TOTAL)) i_vcnt (
        .clk(clk), .rst_n(rst_n), .step(h_wrap),
        .cnt_q(v_q), .cnt_d(v_d), .wrap(v_wrap)
    );

    // Decode the position the counters enter on this edge
    raster_region_decode #(
        .H_TOTAL(H_TOTAL), .H_SYNC_W(H_SYNC_W), .H_BP(H_BP),
        .H_ACTIVE(H_ACTIVE), .CAL_W(CAL_W), .V_TOTAL(V_TOTAL),
        .V_SYNC_L(V_SYNC_L), .V_BP_L(V_BP_L), .V_ACTIVE(V_ACTIVE)
    ) i_dec (
        .h(h_d), .v(v_d), .rgn(rgn), .hoff(hoff), .voff(voff)
    );

    raster_level_mux #(
        .PIX_W(PIX_W), .SQ_LOG2(SQ_LOG2), .HW(HW), .VW(VW)
    ) i_mux (
        .rgn(rgn), .test_en(test_en), .pix_in(pix_in),
        .hoff(hoff), .voff(voff), .lvl(lvl_n), .data(data_n)
    );

    always_comb begin
        seq_d      = seq_q;
        seq_d.lvl  = lvl_n;
        seq_d.data = data_n;
        seq_d.col  = rgn.act_h && rgn.act_v;
        seq_d.row  = rgn.line_head && rgn.act_v;
        seq_d.cal  = rgn.cal;
        seq_d.fs   = rgn.field_head;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{lvl: LVL_BLANK, data: '0, row: 1'b0, col: 1'b0,
                       cal: 1'b0, fs: 1'b0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign lvl_sel     = seq_q.lvl;
    assign data_out    = seq_q.data;
    assign row_adv     = seq_q.row;
    assign col_adv     = seq_q.col;
    assign cal_win     = seq_q.cal;
    assign field_start = seq_q.fs;

    logic unused_wrap;
    assign unused_wrap = v_wrap ^ (|v_q) ^ (|h_q);
endmodule

// File: rtl/raster_fmt_seq_chk.sv
module raster_fmt_seq_chk #(
    parameter int PIX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       lvl_sel,
    input logic [PIX_W-1:0] data_out,
    input logic             row_adv,
    input logic             col_adv,
    input logic             cal_win,
    input logic             field_start
);
    // R4
    no_rsvd_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_sel != 2'b11);

    // R4
    col_matches_image_chk: assert property (@(posedge clk) disable iff (!rst_n)
        col_adv == (lvl_sel == 2'b10));

    // R7
    cal_outside_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cal_win |-> (!col_adv && lvl_sel == 2'b00));

    // R7
    cal_follows_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cal_win) |-> $past(lvl_sel) == 2'b01);

    // R5
    data_only_in_image_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_sel != 2'b10) |-> (data_out == '0));

    // R8
    row_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        row_adv |=> !row_adv);

    // R9
    field_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |=> !field_start);

    // R9
    field_in_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        field_start |-> lvl_sel == 2'b01);
endmodule

bind raster_fmt_seq raster_fmt_seq_chk #(.PIX_W(PIX_W)) i_chk (
    .clk(clk), .rst_n(rst_n), .lvl_sel(lvl_sel), .data_out(data_out),
    .row_adv(row_adv), .col_adv(col_adv), .cal_win(cal_win),
    .field_start(field_start)
);

// File: tb/test_raster_fmt_seq.sv
module test_raster_fmt_seq;
    localparam int PIX_W = 8;
    localparam int HT = 24, HS = 3, HB = 5, HA = 12, CW = 4;
    localparam int VT = 14, VS = 2, VB = 2, VA = 8, SQ = 1;
    localparam int FIELD = HT * VT;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic test_en = 1'b0;
    logic [PIX_W-1:0] pix_in = '0;
    logic [1:0] lvl_sel;
    logic [PIX_W-1:0] data_out;
    logic row_adv, col_adv, cal_win, field_start;

    int checks = 0;
    int failures = 0;
    int mh = -1, mv = -1;
    int e_lvl, e_data, e_row, e_col, e_cal, e_fs;
    int cyc = 0, last_fs = -1;
    bit done = 0;

    always #2.5 clk = ~clk;

    raster_fmt_seq #(
        .PIX_W(PIX_W), .H_TOTAL(HT), .H_SYNC_W(HS), .H_BP(HB), .H_ACTIVE(HA),
        .CAL_W(CW), .V_TOTAL(VT), .V_SYNC_L(VS), .V_BP_L(VB), .V_ACTIVE(VA),
        .SQ_LOG2(SQ)
    ) i_raster_fmt_seq (
        .clk(clk), .rst_n(rst_n), .test_en(test_en), .pix_in(pix_in),
        .lvl_sel(lvl_sel), .data_out(data_out), .row_adv(row_adv),
        .col_adv(col_adv), .cal_win(cal_win), .field_start(field_start)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s at h=%0d v=%0d: actual=%0d expected=%0d",
                     req, what, mh, mv, act, exp);
        end
    endtask

    task automatic set_reset_exp();
        mh = -1; mv = -1;
        e_lvl = 0; e_data = 0; e_row = 0; e_col = 0; e_cal = 0; e_fs = 0;
    endtask

    // Advance the model one pixel and predict outputs from current inputs
    task automatic model_step();
        bit vs, av, ah;
        if (mh < 0) begin mh = 0; mv = 0; end
        else begin
            mh++;
            if (mh == HT) begin mh = 0; mv = (mv + 1) % VT; end
        end
        vs = (mv < VS);
        av = (mv >= VS + VB) && (mv < VS + VB + VA);
        ah = (mh >= HS + HB) && (mh < HS + HB + HA);
        if (vs)          e_lvl = (mh < HT - HS) ? 1 : 0;
        else if (mh < HS) e_lvl = 1;
        else if (av && ah) e_lvl = 2;
        else             e_lvl = 0;
        if (e_lvl == 2) begin
            if (test_en)
                e_data = ((((mh - HS - HB) >> SQ) ^ ((mv - VS - VB) >> SQ)) & 1)
                         ? 255 : 0;
            else
                e_data = pix_in;
        end else e_data = 0;
        e_col = (av && ah) ? 1 : 0;
        e_row = (av && mh == 0) ? 1 : 0;
        e_cal = (!vs && mh >= HS && mh < HS + CW) ? 1 : 0;
        e_fs  = (mh == 0 && mv == 0) ? 1 : 0;
    endtask

    task automatic compare_all(input bit in_reset);
        string lr;
        if (in_reset) begin
            // R1
            chk(lvl_sel == 2'b00 && data_out == 0 && !row_adv && !col_adv &&
                !cal_win && !field_start, "R1", "reset outputs",
                {lvl_sel, row_adv, col_adv, cal_win, field_start}, 0);
            return;
        end
        if (mv < VS) lr = "R3";
        else if (mh < HS) lr = "R2";
        else lr = "R4";
        chk(lvl_sel == e_lvl, lr, "lvl_sel", lvl_sel, e_lvl);
        chk(data_out == e_data, (test_en ? "R6" : "R5"), "data_out", data_out, e_data);
        chk(col_adv == e_col, "R4", "col_adv", col_adv, e_col);
        chk(cal_win == e_cal, "R7", "cal_win", cal_win, e_cal);
        chk(row_adv == e_row, "R8", "row_adv", row_adv, e_row);
        chk(field_start == e_fs, "R9", "field_start", field_start, e_fs);
        if (mh == 0 && mv == 0 && field_start !== 1'b0)
            chk(1'b1, "R1", "first position after reset", 0, 0);
        if (field_start) begin
            if (last_fs >= 0)
                chk(cyc - last_fs == FIELD, "R9", "field period", cyc - last_fs, FIELD);
            last_fs = cyc;
        end
    endtask

    // One clock: check the pixel entered at the last edge, then drive inputs
    task automatic run_cycles(input int n, input int mode);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cyc++;
            compare_all(1'b0);
            pix_in = PIX_W'($urandom);
            if (mode == 1) test_en = 1'b0;
            else if (mode == 2) test_en = 1'b1;
            else test_en = $urandom_range(0, 1) == 1;
            model_step();
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        set_reset_exp();
        last_fs = -1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            compare_all(1'b1);
        end
        rst_n = 1'b1;
        // R1: first edge after release enters line 0 pixel 0
        model_step();
    endtask

    initial begin
        set_reset_exp();
        test_en = 1'b0;
        do_reset();
        run_cycles(2 * FIELD, 1);
        run_cycles(2 * FIELD, 2);
        run_cycles(FIELD, 3);
        run_cycles(FIELD / 2 + 7, 1);
        do_reset();
        run_cycles(FIELD + 5, 2);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule